// File: doc/BRIEF.md
# Pooled Partition Allocator

This block is the central manager for storage partitions that four cores share across a vertical stack. Each core's queue and register structures are split into fixed partitions. Every partition is either owned by exactly one core or sits unowned in a common free pool. The block tracks the owner of every partition and how many partitions each core holds. It publishes the ownership map, which the partitioned storage uses to route its accesses.

A core raises its request line when its structure is full. If a partition is free and the core is below its ceiling, the block grants it one. The storage reports which partitions are empty. An empty partition is taken back into the pool straight away, as long as its owner stays above its floor. A partition that holds live entries is never moved. When several cores ask in the same cycle, a rotating priority picks one winner. The floor and the ceiling are shared limits that can be loaded at run time, and a load is accepted only if the pair makes sense.

Top module: `part_pool_alloc`

## Requirements
- R1: After reset, partition p is owned by core p/4: `owned` is all ones, slice `owner_id[2p+1:2p]` equals p/4, every core holds four partitions, and `grant_valid` is 0.
- R2: If a core's request bit is high, a partition is free and the core holds fewer partitions than the ceiling, the lowest-numbered free partition goes to that core. `owned`, `owner_id`, `grant_valid`, `grant_core` and `grant_part` show the grant one clock later.
- R3: No grant is made while no partition is free (`owned` all ones).
- R4: A core whose partition count equals or exceeds the ceiling receives no grant.
- R5: An owned partition whose `part_empty` bit is high is freed one clock later if its owner holds more than the floor. A core gives up at most one partition per cycle, and the lowest-numbered empty one goes first. Different cores can give up partitions in the same cycle.
- R6: A core that holds the floor or fewer keeps its empty partitions.
- R7: A partition whose `part_empty` bit is low keeps its owner and its `owner_id`.
- R8: At most one grant is made per cycle. Among the eligible requesters, the first one at or after the rotating pointer wins, checking in ascending core order. The pointer then moves to the core after the winner.
- R9: A pulse on `cfg_load` loads `cfg_min` as the floor and `cfg_max` as the ceiling only if 1 <= cfg_max <= 16 and cfg_min <= cfg_max. Otherwise the pulse is ignored and the old limits stay. New limits take effect from the next cycle.
- R10: After reset, the floor is 2 (one eighth of the 16-partition pool) and the ceiling is 16 (the whole pool).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_full | input | 4 | Per-core request: the core's structure is full |
| part_empty | input | 16 | Per-partition empty indication from the storage |
| cfg_load | input | 1 | Load pulse for the limit pair |
| cfg_min | input | 5 | Proposed floor (partition count) |
| cfg_max | input | 5 | Proposed ceiling (partition count) |
| owned | output | 16 | Bit p is high when partition p has an owner |
| owner_id | output | 32 | Two bits per partition: owning core of partition p at [2p+1:2p] |
| grant_valid | output | 1 | A grant was made on the previous clock |
| grant_core | output | 2 | Core that received that grant |
| grant_part | output | 4 | Partition that was granted |

## Verification
Grants are exercised with three request patterns: a single requester, which shows lowest-free-partition selection; a three-core request repeated while the pointer moves, which shows rotating priority apart from fixed priority; and the same request into an exhausted pool, which shows that the free-pool condition is checked. Release is driven with empty flags held on one core across several cycles, which separates one-per-cycle harvest from bulk harvest and shows where the floor stops it. Empty flags are also raised on two cores at once, to show that release is independent per core. Limit loads are tried with an out-of-range ceiling, with an inverted pair and with a valid pair, and each is followed by a request that only a wrongly accepted ceiling would grant.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  localparam int VW = 64;
  typedef logic [VW-1:0] vec_t;

  function automatic int lowest_set(vec_t v);
    int idx;
    logic found;
    idx = 0;
    found = 1'b0;
    for (int i = 0; i < VW; i++) begin
      if (v[i] && !found) begin
        idx = i;
        found = 1'b1;
      end
    end
    return idx;
  endfunction

  function automatic int rr_pick(vec_t req, int ptr, int n);
    int idx;
    int k_idx;
    logic found;
    idx = 0;
    found = 1'b0;
    for (int k = 0; k < VW; k++) begin
      if (k < n) begin
        k_idx = (ptr + k) % n;
        if (req[k_idx] && !found) begin
          idx = k_idx;
          found = 1'b1;
        end
      end
    end
    return idx;
  endfunction

  function automatic logic limits_ok(int mn, int mx, int total);
    return (mx >= 1) && (mx <= total) && (mn <= mx);
  endfunction

endpackage

// File: rtl/ppa_limits.sv
module ppa_limits #(
  parameter int NPART   = 16,
  parameter int CNTW    = 5,
  parameter int MIN_RST = 2,
  parameter int MAX_RST = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [CNTW-1:0] cfg_min,
  input  logic [CNTW-1:0] cfg_max,
  output logic [CNTW-1:0] lim_min,
  output logic [CNTW-1:0] lim_max
);

  logic cfg_take;

  assign cfg_take = cfg_load && ppa_pkg::limits_ok(int'(cfg_min), int'(cfg_max), NPART);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_min <= CNTW'(MIN_RST);
      lim_max <= CNTW'(MAX_RST);
    end else if (cfg_take) begin
      lim_min <= cfg_min;
      lim_max <= cfg_max;
    end
  end

endmodule

// File: rtl/ppa_harvest.sv
module ppa_harvest #(
  parameter int NCORE = 4,
  parameter int NPART = 16,
  parameter int CIDW  = 2,
  parameter int CNTW  = 5
) (
  input  logic [NPART-1:0]      owned,
  input  logic [NPART*CIDW-1:0] owner_id,
  input  logic [NPART-1:0]      part_empty,
  input  logic [NCORE*CNTW-1:0] cnt_flat,
  input  logic [CNTW-1:0]       lim_min,
  output logic [NPART-1:0]      rel_mask,
  output logic [NCORE-1:0]      rel_core
);

  logic [NPART-1:0] core_mask [NCORE];

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [NPART-1:0] mine;
    logic [CNTW-1:0]  held;
    int               pick;

    assign held = cnt_flat[c*CNTW +: CNTW];

    always_comb begin
      for (int p = 0; p < NPART; p++) begin
        mine[p] = owned[p] && part_empty[p] &&
                  (owner_id[p*CIDW +: CIDW] == CIDW'(c));
      end
    end

    assign pick        = ppa_pkg::lowest_set(ppa_pkg::vec_t'(mine));
    assign rel_core[c] = (|mine) && (held > lim_min);

    always_comb begin
      core_mask[c] = '0;
      if (rel_core[c]) core_mask[c][pick] = 1'b1;
    end
  end

  always_comb begin
    rel_mask = '0;
    for (int c = 0; c < NCORE; c++) rel_mask = rel_mask | core_mask[c];
  end

endmodule

// File: rtl/ppa_rr_arb.sv
module ppa_rr_arb #(
  parameter int NCORE = 4,
  parameter int CIDW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] elig,
  output logic             fire,
  output logic [CIDW-1:0]  win
);

  logic [CIDW-1:0] ptr;

  assign fire = |elig;
  assign win  = CIDW'(ppa_pkg::rr_pick(ppa_pkg::vec_t'(elig), int'(ptr), NCORE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (fire) begin
      ptr <= CIDW'((int'(win) + 1) % NCORE);
    end
  end

endmodule

// File: rtl/ppa_owner_table.sv
module ppa_owner_table #(
  parameter int NCORE         = 4,
  parameter int PART_PER_CORE = 4,
  parameter int NPART         = 16,
  parameter int CIDW          = 2,
  parameter int PIDW          = 4,
  parameter int CNTW          = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grant_fire,
  input  logic [CIDW-1:0]       gnt_core,
  input  logic [PIDW-1:0]       gnt_part,
  input  logic [NPART-1:0]      rel_mask,
  input  logic [NCORE-1:0]      rel_core,
  output logic [NPART-1:0]      owned,
  output logic [NPART*CIDW-1:0] owner_id,
  output logic [NCORE*CNTW-1:0] cnt_flat,
  output logic                  grant_valid,
  output logic [CIDW-1:0]       grant_core,
  output logic [PIDW-1:0]       grant_part
);

  logic [CNTW-1:0] cnt_q [NCORE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPART; p++) begin
        owned[p]                  <= 1'b1;
        owner_id[p*CIDW +: CIDW]  <= CIDW'(p / PART_PER_CORE);
      end
    end else begin
      for (int p = 0; p < NPART; p++) begin
        if (rel_mask[p]) begin
          owned[p] <= 1'b0;
        end else if (grant_fire && (gnt_part == PIDW'(p))) begin
          owned[p]                 <= 1'b1;
          owner_id[p*CIDW +: CIDW] <= gnt_core;
        end
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_cnt
    logic take;
    assign take = grant_fire && (gnt_core == CIDW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[c] <= CNTW'(PART_PER_CORE);
      end else begin
        cnt_q[c] <= cnt_q[c] - CNTW'(rel_core[c]) + CNTW'(take);
      end
    end

    assign cnt_flat[c*CNTW +: CNTW] = cnt_q[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_core  <= '0;
      grant_part  <= '0;
    end else begin
      grant_valid <= grant_fire;
      if (grant_fire) begin
        grant_core <= gnt_core;
        grant_part <= gnt_part;
      end
    end
  end

endmodule

// File: rtl/part_pool_alloc.sv
module part_pool_alloc #(
  parameter int NCORE         = 4,
  parameter int PART_PER_CORE = 4,
  localparam int NPART        = NCORE * PART_PER_CORE,
  localparam int CIDW         = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int PIDW         = (NPART > 1) ? $clog2(NPART) : 1,
  localparam int CNTW         = $clog2(NPART + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      req_full,
  input  logic [NPART-1:0]      part_empty,
  input  logic                  cfg_load,
  input  logic [CNTW-1:0]       cfg_min,
  input  logic [CNTW-1:0]       cfg_max,
  output logic [NPART-1:0]      owned,
  output logic [NPART*CIDW-1:0] owner_id,
  output logic                  grant_valid,
  output logic [CIDW-1:0]       grant_core,
  output logic [PIDW-1:0]       grant_part
);

  localparam int MIN_RST = NPART / 8;
  localparam int MAX_RST = NPART;

  logic [CNTW-1:0]       lim_min;
  logic [CNTW-1:0]       lim_max;
  logic [NCORE*CNTW-1:0] cnt_flat;
  logic [NPART-1:0]      rel_mask;
  logic [NCORE-1:0]      rel_core;
  logic [NCORE-1:0]      elig;
  logic                  free_any;
  logic                  grant_fire;
  logic [CIDW-1:0]       gnt_core;
  logic [PIDW-1:0]       gnt_part;

  ppa_limits #(
    .NPART(NPART), .CNTW(CNTW), .MIN_RST(MIN_RST), .MAX_RST(MAX_RST)
  ) u_limits (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_min(cfg_min), .cfg_max(cfg_max),
    .lim_min(lim_min), .lim_max(lim_max)
  );

  ppa_harvest #(
    .NCORE(NCORE), .NPART(NPART), .CIDW(CIDW), .CNTW(CNTW)
  ) u_harvest (
    .owned(owned), .owner_id(owner_id), .part_empty(part_empty),
    .cnt_flat(cnt_flat), .lim_min(lim_min),
    .rel_mask(rel_mask), .rel_core(rel_core)
  );

  assign free_any = ~&owned;
  assign gnt_part = PIDW'(ppa_pkg::lowest_set(ppa_pkg::vec_t'(~owned)));

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      elig[c] = req_full[c] && free_any && (cnt_flat[c*CNTW +: CNTW] < lim_max);
    end
  end

  ppa_rr_arb #(
    .NCORE(NCORE), .CIDW(CIDW)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig),
    .fire(grant_fire), .win(gnt_core)
  );

  ppa_owner_table #(
    .NCORE(NCORE), .PART_PER_CORE(PART_PER_CORE), .NPART(NPART),
    .CIDW(CIDW), .PIDW(PIDW), .CNTW(CNTW)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .grant_fire(grant_fire),
    .gnt_core(gnt_core), .gnt_part(gnt_part),
    .rel_mask(rel_mask), .rel_core(rel_core),
    .owned(owned), .owner_id(owner_id), .cnt_flat(cnt_flat),
    .grant_valid(grant_valid), .grant_core(grant_core), .grant_part(grant_part)
  );

endmodule

// File: rtl/ppa_checker.sv
module ppa_checker #(
  parameter int NCORE = 4,
  parameter int NPART = 16,
  parameter int CIDW  = 2,
  parameter int PIDW  = 4,
  parameter int CNTW  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCORE-1:0]      req_full,
  input logic [NPART-1:0]      part_empty,
  input logic [NPART-1:0]      owned,
  input logic [NPART*CIDW-1:0] owner_id,
  input logic                  grant_fire,
  input logic [CIDW-1:0]       gnt_core,
  input logic [PIDW-1:0]       gnt_part,
  input logic [NPART-1:0]      rel_mask,
  input logic [NCORE-1:0]      rel_core,
  input logic [NCORE*CNTW-1:0] cnt_flat,
  input logic [CNTW-1:0]       lim_min,
  input logic [CNTW-1:0]       lim_max,
  input logic                  grant_valid
);

  int cnt_sum;
  always_comb begin
    cnt_sum = 0;
    for (int c = 0; c < NCORE; c++) cnt_sum += int'(cnt_flat[c*CNTW +: CNTW]);
  end

  // R1: per-core counters agree with the ownership map
  a_r1_counts_match_map: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sum == $countones(owned));

  a_r2_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> (req_full[gnt_core] && !owned[gnt_part]));

  a_r2_grant_lands: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> (grant_valid && owned[$past(gnt_part)]));

  a_r3_no_grant_when_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
    (&owned) |-> !grant_fire);

  a_r4_below_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> (cnt_flat[gnt_core*CNTW +: CNTW] < lim_max));

  a_r5_one_release_per_core: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rel_mask) == $countones(rel_core));

  for (genvar p = 0; p < NPART; p++) begin : g_part
    a_r5_release_empty_owned: assert property (@(posedge clk) disable iff (!rst_n)
      rel_mask[p] |-> (part_empty[p] && owned[p]));

    a_r5_release_lands: assert property (@(posedge clk) disable iff (!rst_n)
      rel_mask[p] |=> !owned[p]);

    a_r7_live_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (owned[p] && !part_empty[p]) |=> (owned[p] && $stable(owner_id[p*CIDW +: CIDW])));
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    a_r6_keep_floor: assert property (@(posedge clk) disable iff (!rst_n)
      rel_core[c] |-> (cnt_flat[c*CNTW +: CNTW] > lim_min));
  end

endmodule

bind part_pool_alloc ppa_checker #(
  .NCORE(NCORE), .NPART(NPART), .CIDW(CIDW), .PIDW(PIDW), .CNTW(CNTW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_full(req_full), .part_empty(part_empty),
  .owned(owned), .owner_id(owner_id), .grant_fire(grant_fire),
  .gnt_core(gnt_core), .gnt_part(gnt_part), .rel_mask(rel_mask),
  .rel_core(rel_core), .cnt_flat(cnt_flat), .lim_min(lim_min),
  .lim_max(lim_max), .grant_valid(grant_valid)
);

// File: tb/tb_part_pool_alloc.sv
`timescale 1ns/1ps
module tb_part_pool_alloc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req_full;
  logic [15:0] part_empty;
  logic        cfg_load;
  logic [4:0]  cfg_min;
  logic [4:0]  cfg_max;
  logic [15:0] owned;
  logic [31:0] owner_id;
  logic        grant_valid;
  logic [1:0]  grant_core;
  logic [3:0]  grant_part;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  part_pool_alloc dut (
    .clk(clk), .rst_n(rst_n), .req_full(req_full), .part_empty(part_empty),
    .cfg_load(cfg_load), .cfg_min(cfg_min), .cfg_max(cfg_max),
    .owned(owned), .owner_id(owner_id), .grant_valid(grant_valid),
    .grant_core(grant_core), .grant_part(grant_part)
  );

  // {req[42:39], empty[38:23], gv[22], gc[21:20], gp[19:16], owned[15:0]}
  localparam logic [42:0] VEC [10] = '{
    {4'h0, 16'h000F, 1'b0, 2'd0, 4'd0, 16'hFFFE},  // R5 release p0
    {4'h0, 16'h000F, 1'b0, 2'd0, 4'd0, 16'hFFFC},  // R5 release p1
    {4'h0, 16'h000F, 1'b0, 2'd0, 4'd0, 16'hFFFC},  // R6 floor 2 holds
    {4'h2, 16'h0000, 1'b1, 2'd1, 4'd0, 16'hFFFD},  // R2 single requester
    {4'hB, 16'h0000, 1'b1, 2'd3, 4'd1, 16'hFFFF},  // R8 pointer at 2 -> core 3
    {4'hB, 16'h0000, 1'b0, 2'd0, 4'd0, 16'hFFFF},  // R3 pool exhausted
    {4'h0, 16'h0010, 1'b0, 2'd0, 4'd0, 16'hFFEF},  // R5 release p4
    {4'hB, 16'h0000, 1'b1, 2'd0, 4'd4, 16'hFFFF},  // R8 pointer at 0 -> core 0
    {4'h2, 16'h0100, 1'b0, 2'd0, 4'd0, 16'hFEFF},  // R3 request, release same cycle
    {4'hB, 16'h0000, 1'b1, 2'd1, 4'd8, 16'hFFFF}   // R8 pointer at 1 -> core 1
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic [3:0] r, input logic [15:0] e);
    req_full   = r;
    part_empty = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic [4:0] mn, input logic [4:0] mx);
    cfg_load = 1'b1;
    cfg_min  = mn;
    cfg_max  = mx;
    cycle(4'h0, 16'h0000);
    cfg_load = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_full = '0; part_empty = '0; cfg_load = 1'b0; cfg_min = '0; cfg_max = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    check(owned == 16'hFFFF, "R1", "owned", owned, 16'hFFFF);
    check(grant_valid == 1'b0, "R1", "grant_valid", grant_valid, 0);
    for (int p = 0; p < 16; p++) begin
      check(owner_id[p*2 +: 2] == 2'(p / 4), "R1", "owner_id", owner_id[p*2 +: 2], p / 4);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_reset_state();

    for (int i = 0; i < 10; i++) begin
      logic [42:0] v;
      v = VEC[i];
      cycle(v[42:39], v[38:23]);
      check(owned == v[15:0], "R2 R3 R5 R6 R7 R8", "owned", owned, v[15:0]);
      check(grant_valid == v[22], "R2 R3 R8", "grant_valid", grant_valid, v[22]);
      if (v[22]) begin
        check(grant_core == v[21:20], "R8", "grant_core", grant_core, v[21:20]);
        check(grant_part == v[19:16], "R2", "grant_part", grant_part, v[19:16]);
      end
    end
    check(owner_id[1:0] == 2'd1, "R2", "owner of p0", owner_id[1:0], 1);
    check(owner_id[3:2] == 2'd3, "R2", "owner of p1", owner_id[3:2], 3);
    check(owner_id[9:8] == 2'd0, "R2", "owner of p4", owner_id[9:8], 0);
    check(owner_id[17:16] == 2'd1, "R2", "owner of p8", owner_id[17:16], 1);

    // R10: default floor 2 and ceiling above four
    do_reset();
    check_reset_state();
    repeat (3) cycle(4'h0, 16'h00F0);
    check(owned == 16'hFFCF, "R10", "floor 2 after harvest", owned, 16'hFFCF);
    cycle(4'h1, 16'h0000);
    cycle(4'h1, 16'h0000);
    check(owned == 16'hFFFF, "R10", "core0 grows to 6", owned, 16'hFFFF);
    check(owner_id[11:10] == 2'd0, "R10", "owner of p5", owner_id[11:10], 0);

    // R4: ceiling 4, core0 holds 6
    load_cfg(5'd0, 5'd4);
    cycle(4'h0, 16'h0100);
    check(owned == 16'hFEFF, "R4", "p8 freed", owned, 16'hFEFF);
    cycle(4'h1, 16'h0000);
    check(grant_valid == 1'b0, "R4", "no grant at ceiling", grant_valid, 0);
    check(owned == 16'hFEFF, "R4", "pool unchanged", owned, 16'hFEFF);
    cycle(4'h2, 16'h0000);
    check(grant_valid == 1'b1 && grant_core == 2'd1 && grant_part == 4'd8,
          "R4", "core1 under ceiling granted", {grant_valid, grant_core, grant_part}, 7'h58);

    // R9: invalid limit loads ignored
    cycle(4'h0, 16'h0200);
    check(owned == 16'hFDFF, "R9", "p9 freed", owned, 16'hFDFF);
    load_cfg(5'd1, 5'd17);
    cycle(4'h1, 16'h0000);
    check(grant_valid == 1'b0, "R9", "ceiling 17 rejected", grant_valid, 0);
    load_cfg(5'd9, 5'd8);
    cycle(4'h1, 16'h0000);
    check(grant_valid == 1'b0, "R9", "inverted pair rejected", grant_valid, 0);
    load_cfg(5'd0, 5'd8);
    cycle(4'h1, 16'h0000);
    check(grant_valid == 1'b1 && grant_part == 4'd9, "R9", "valid pair accepted",
          {grant_valid, grant_part}, 5'h19);

    // R5: two cores release together, one partition each per cycle
    cycle(4'h0, 16'hF0C0);
    check(owned == 16'hEFBF, "R5", "first release pair", owned, 16'hEFBF);
    cycle(4'h0, 16'hF0C0);
    check(owned == 16'hCF3F, "R5", "second release pair", owned, 16'hCF3F);
    check(grant_valid == 1'b0, "R5", "no grant while releasing", grant_valid, 0);
    check(owner_id[1:0] == 2'd0 && owned[0], "R7", "live p0 kept", owner_id[1:0], 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule